// File: doc/BRIEF.md
# Soft Mute Volume Ramp Controller

This block generates the gain multiplier that an audio datapath applies to every sample. It changes the gain only once per audio frame and by no more than a fixed step each time, so mute and unmute produce a smooth linear fade with no audible click. When soft mute is raised, the gain falls toward zero. When soft mute is released, the gain climbs back to the stored volume word and stops exactly on it. A change to the volume word while unmuted is also approached by the same ramp.

A halt request uses the same fade toward zero. Once the gain sits at zero, the block raises a halt-complete status bit, which is bit 1 of the control readback, and withdraws the clock enable of the processing core. Soft power-down also withdraws that clock enable. During power-down the gain is frozen but no state is lost. Only the external reset clears the block.

Gain is unsigned fixed point with unity equal to 2^22. One frame step is unity/512 (8192), so a fade between unity and zero takes exactly 512 frames.

Top module: `soft_mute_ramp`

## Requirements
- R1: After reset, `gain` is 0, `halt_done` is 0 and `core_clk_en` is 1.
- R2: `gain` changes only at a clock edge where `frame_stb` is 1 and `pdn_req` is 0. Each such change moves the gain by at most one step, and a step is 8192.
- R3: While `mute_req` or `halt_req` is 1, each frame lowers the gain by one step and stops at 0 without wrapping. A fade from 4194304 (unity) to 0 takes exactly 512 frames.
- R4: While both `mute_req` and `halt_req` are 0, each frame raises the gain by one step toward `target_vol`. The gain never exceeds `target_vol` and ends exactly equal to it, even when `target_vol` is not a multiple of the step. A fade from 0 to unity takes exactly 512 frames.
- R5: Releasing mute partway through a fade-down reverses the ramp from the current gain, with no jump.
- R6: Changing `target_vol` while unmuted ramps the gain toward the new value, one step per frame, in either direction.
- R7: While `halt_req` is 1, `halt_done` becomes 1 one clock after an edge at which the gain was 0. While `halt_done` is 1, the gain stays 0 and `core_clk_en` is 0.
- R8: A halt fades the gain to zero and completes even when `mute_req` is 0, so halt overrides a released mute.
- R9: At the first clock edge with `halt_req` at 0, `halt_done` clears, and the gain then ramps back toward the goal.
- R10: While `pdn_req` is 1, `core_clk_en` is 0 and the gain holds through any frame strobes. After `pdn_req` returns to 0, the ramp continues from the held gain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low external reset, the only clear |
| frame_stb | input | 1 | One-cycle pulse per audio frame |
| target_vol | input | 24 | Stored volume word, unity = 2^22 |
| mute_req | input | 1 | Soft-mute control, 1 = fade to zero |
| halt_req | input | 1 | Halt control, 1 = fade down then stop the core |
| pdn_req | input | 1 | Soft power-down, gates the core clock |
| gain | output | 24 | Current per-frame gain multiplier |
| halt_done | output | 1 | Halt-complete status (readback bit 1) |
| core_clk_en | output | 1 | Clock enable for the processing core |

## Verification
The hardest situations to reach from the ports are the ones where several controls change partway through a fade. Examples are a mute released mid-descent, a halt raised while unmuted with a non-step-aligned gain, and power-down arriving between frame strobes during a halt. Directed sequences count exact frame numbers to set up these mid-ramp states and to check the 512-frame fade lengths. Seeded random toggling of mute, halt, power-down, strobe and volume then drives long runs through the other combinations, and a bench model compares all three outputs on every cycle.

// File: rtl/svr_pkg.sv
package svr_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/svr_goal_sel.sv
module svr_goal_sel #(
  parameter int GAIN_W = 24
) (
  input  logic [GAIN_W-1:0] target_vol,
  input  logic              mute_req,
  input  logic              halt_req,
  output logic [GAIN_W-1:0] goal,
  output logic              fade_out
);
  // Halt wins over a released mute: either request drives the goal to zero.
  always_comb begin
    fade_out = mute_req | halt_req;
    goal     = fade_out ? '0 : target_vol;
  end
endmodule

// File: rtl/svr_ramp.sv
module svr_ramp
  import svr_pkg::*;
#(
  parameter int GAIN_W    = 24,
  parameter int FRAC_W    = 22,
  parameter int RAMP_LOG2 = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [GAIN_W-1:0] goal,
  output logic [GAIN_W-1:0] gain,
  output ramp_dir_e         dir
);
  localparam int STEP_SH = FRAC_W - RAMP_LOG2;
  localparam logic [GAIN_W-1:0] STEP = {{(GAIN_W-1){1'b0}}, 1'b1} << STEP_SH;

  // One frame of movement toward the goal, clamped so it lands on it exactly.
  function automatic logic [GAIN_W-1:0] step_toward(
    input logic [GAIN_W-1:0] cur,
    input logic [GAIN_W-1:0] tgt
  );
    logic [GAIN_W-1:0] gap;
    if (cur > tgt) begin
      gap = cur - tgt;
      return (gap > STEP) ? cur - STEP : tgt;
    end else begin
      gap = tgt - cur;
      return (gap > STEP) ? cur + STEP : tgt;
    end
  endfunction

  logic [GAIN_W-1:0] gain_nxt;

  always_comb begin
    if (gain > goal)      dir = DIR_DOWN;
    else if (gain < goal) dir = DIR_UP;
    else                  dir = DIR_HOLD;
    gain_nxt = step_toward(gain, goal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   gain <= '0;
    else if (adv) gain <= gain_nxt;
  end

  // R2: no frame advance, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(gain));
  // R2: bounded step size per frame
  p_step_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (((gain > $past(gain)) ? (gain - $past(gain)) : ($past(gain) - gain)) <= STEP));
  // R4: never climbs past the goal
  p_no_overshoot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && dir != DIR_DOWN) |=> (gain <= $past(goal)));
  // R3: never falls past the goal
  p_no_undershoot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && dir != DIR_UP) |=> (gain >= $past(goal)));
  // R5: movement follows the direction decided before the edge
  p_dir_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && dir == DIR_DOWN) |=> (gain < $past(gain)));
endmodule

// File: rtl/svr_halt_seq.sv
module svr_halt_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic gain_zero,
  input  logic pdn_req,
  output logic halt_done,
  output logic core_clk_en
);
  logic done_nxt;

  always_comb begin
    done_nxt    = halt_req & (halt_done | gain_zero);
    core_clk_en = ~pdn_req & ~halt_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_done <= 1'b0;
    else        halt_done <= done_nxt;
  end

  // R7: status only while the gain really is at zero
  p_done_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_done |-> gain_zero);
  // R7: completes one clock after zero is seen under halt
  p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && gain_zero) |=> halt_done);
  // R9: released halt clears status at the next edge
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_req |=> !halt_done);
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
  import svr_pkg::*;
#(
  parameter int GAIN_W    = 24,
  parameter int FRAC_W    = 22,
  parameter int RAMP_LOG2 = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [GAIN_W-1:0] target_vol,
  input  logic              mute_req,
  input  logic              halt_req,
  input  logic              pdn_req,
  output logic [GAIN_W-1:0] gain,
  output logic              halt_done,
  output logic              core_clk_en
);
  logic [GAIN_W-1:0] goal;
  logic              fade_out;
  logic              frame_adv;
  logic              gain_zero;
  ramp_dir_e         ramp_dir;

  assign frame_adv = frame_stb & ~pdn_req;
  assign gain_zero = (gain == '0);

  svr_goal_sel #(.GAIN_W(GAIN_W)) u_goal (
    .target_vol(target_vol),
    .mute_req  (mute_req),
    .halt_req  (halt_req),
    .goal      (goal),
    .fade_out  (fade_out)
  );

  svr_ramp #(.GAIN_W(GAIN_W), .FRAC_W(FRAC_W), .RAMP_LOG2(RAMP_LOG2)) u_ramp (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (frame_adv),
    .goal (goal),
    .gain (gain),
    .dir  (ramp_dir)
  );

  svr_halt_seq u_halt (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_req   (halt_req),
    .gain_zero  (gain_zero),
    .pdn_req    (pdn_req),
    .halt_done  (halt_done),
    .core_clk_en(core_clk_en)
  );

  // R10: power-down freezes the gain even with a strobe present
  p_pdn_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_req |=> $stable(gain));
  // R8: a fade request never lets the gain climb
  p_fade_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fade_out |=> (gain <= $past(gain)));
  // R7: core is stopped whenever the halt has completed
  p_core_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_done |-> !core_clk_en);
endmodule

// File: tb/tb_soft_mute_ramp.sv
module tb_soft_mute_ramp;
  localparam int W = 24;
  localparam longint UNITY = 64'd1 << 22;
  localparam longint STEP  = UNITY / 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_stb = 1'b0;
  logic [W-1:0] target_vol = '0;
  logic mute_req = 1'b0, halt_req = 1'b0, pdn_req = 1'b0;
  logic [W-1:0] gain;
  logic halt_done, core_clk_en;

  int checks = 0, fails = 0;
  longint m_gain = 0;
  bit m_done = 1'b0;
  string tag = "R1";
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  soft_mute_ramp dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .target_vol(target_vol),
    .mute_req(mute_req), .halt_req(halt_req), .pdn_req(pdn_req),
    .gain(gain), .halt_done(halt_done), .core_clk_en(core_clk_en)
  );

  // Expected gain after one frame, written as a signed clamp.
  function automatic longint model_step(longint cur, longint goal);
    longint d = goal - cur;
    if (d > STEP)  d = STEP;
    if (d < -STEP) d = -STEP;
    return cur + d;
  endfunction

  task automatic check(string name, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, name, act, exp);
    end
  endtask

  task automatic compare();
    check("gain", longint'(gain), m_gain);
    check("halt_done", longint'(halt_done), longint'(m_done));
    check("core_clk_en", longint'(core_clk_en), longint'(!pdn_req && !m_done));
  endtask

  task automatic tick(bit stb);
    longint goal;
    bit was_zero;
    frame_stb = stb;
    @(posedge clk);
    goal = (mute_req || halt_req) ? 0 : longint'(target_vol);
    was_zero = (m_gain == 0);
    if (stb && !pdn_req) m_gain = model_step(m_gain, goal);
    m_done = halt_req && (m_done || was_zero);
    @(negedge clk);
    compare();
  endtask

  task automatic frames(int n);
    for (int i = 0; i < n; i++) begin
      tick(1'b1);
      tick(1'b0);
    end
  endtask

  // Runs frames until the gain equals the value, returns frames used.
  task automatic frames_until(longint v, output int n);
    n = 0;
    while (longint'(gain) != v && n < 4000) begin
      frames(1);
      n++;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    longint held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    compare();
    check("reset gain zero", longint'(gain), 0);

    tag = "R4";
    target_vol = W'(UNITY);
    frames_until(UNITY, n);
    check("frames 0 to unity", n, 512);

    tag = "R3";
    mute_req = 1'b1;
    frames_until(0, n);
    check("frames unity to 0", n, 512);
    frames(3);
    check("clamped at zero", longint'(gain), 0);

    tag = "R4";
    target_vol = 24'h012345;
    mute_req = 1'b0;
    frames(9);
    check("one step below odd target", longint'(gain), 9 * STEP);
    frames(20);
    check("exact odd target", longint'(gain), 64'h12345);

    tag = "R5";
    mute_req = 1'b1;
    frames_until(0, n);
    target_vol = W'(UNITY);
    mute_req = 1'b0;
    frames(100);
    mute_req = 1'b1;
    frames(30);
    check("mid fade down", longint'(gain), 70 * STEP);
    mute_req = 1'b0;
    frames(10);
    check("reversed up", longint'(gain), 80 * STEP);

    tag = "R6";
    target_vol = W'(40 * STEP + 5);
    frames(30);
    check("down to new target", longint'(gain), 50 * STEP);
    frames(11);
    check("at new target", longint'(gain), 40 * STEP + 5);

    tag = "R8";
    halt_req = 1'b1;
    frames(40);
    check("halt fade one step short", longint'(gain), 5);
    frames(1);
    check("halt reached zero", longint'(gain), 0);
    tick(1'b0);
    tag = "R7";
    check("halt_done set", longint'(halt_done), 1);
    check("core stopped", longint'(core_clk_en), 0);
    frames(5);
    check("gain held at zero", longint'(gain), 0);

    tag = "R9";
    halt_req = 1'b0;
    tick(1'b0);
    check("halt_done cleared", longint'(halt_done), 0);
    frames(3);
    check("ramp resumed", longint'(gain), 3 * STEP);

    tag = "R10";
    pdn_req = 1'b1;
    held = longint'(gain);
    frames(20);
    check("frozen gain", longint'(gain), held);
    check("clock gated", longint'(core_clk_en), 0);
    pdn_req = 1'b0;
    frames(2);
    check("continues after pdn", longint'(gain), held + 2 * STEP);

    tag = "R2";
    for (int i = 0; i < 20; i++) tick(1'b0);
    check("no strobe no move", longint'(gain), held + 2 * STEP);

    tag = "random R2";
    void'($urandom(32'd1953));
    for (int i = 0; i < 30000; i++) begin
      if ($urandom_range(0, 199) == 0) mute_req = ~mute_req;
      if ($urandom_range(0, 399) == 0) halt_req = ~halt_req;
      if ($urandom_range(0, 499) == 0) pdn_req = ~pdn_req;
      if ($urandom_range(0, 299) == 0) target_vol = W'($urandom_range(0, 32'(UNITY)));
      tick($urandom_range(0, 1) == 1);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule